// File: doc/BRIEF.md
# Lock-Gated Video Link Start Sequencer

This block sits on the receiving side of a camera serial video link. It holds off capture until the analog video decoder feeding the link has locked to its source. While the decoder searches, the transmitter's link output is kept in power-down and the receiver discards nothing because it captures nothing. The sequencer learns about lock from the decoder's interrupt line and confirms it with a single status register read. Only then does it clear the transmitter's power-down bit. This forces the link clock lane through a fresh low-power to high-speed transition, which a receiver brought up late would otherwise never observe.

Register traffic leaves the block as a plain request/acknowledge handshake. A serial bus master elsewhere turns it into bus cycles. The power-down release waits for a ready flag from the receiver, so the receiver is listening before the clock lane starts. Once capture is running, a later interrupt that reports loss of lock stops capture and restarts the whole sequence. If no interrupt arrives within a programmable number of cycles, an error flag is raised and the sequence is retried.

The states are RESET, ASSERT_PWRDN, WAIT_IRQ, READ_STATUS, CHECK_LOCK, WAIT_RX_READY, RELEASE_PWRDN, CAPTURE and CAPTURE_READ. The transitions are:

- RESET always goes to ASSERT_PWRDN.
- ASSERT_PWRDN goes to WAIT_IRQ when its write completes.
- WAIT_IRQ goes to READ_STATUS on an interrupt event, or back to ASSERT_PWRDN on timeout.
- READ_STATUS goes to CHECK_LOCK when the read completes.
- CHECK_LOCK goes to WAIT_RX_READY if lock is valid, and otherwise back to WAIT_IRQ.
- WAIT_RX_READY goes to RELEASE_PWRDN when the receiver is ready.
- RELEASE_PWRDN goes to CAPTURE when its write completes.
- CAPTURE goes to CAPTURE_READ on an interrupt event.
- CAPTURE_READ returns to CAPTURE if lock is still valid, and otherwise goes to ASSERT_PWRDN.

Top module: `lockgate_seq`

## Requirements
- R1: While reset is low, capture_en_o, lock_err_o and reg_req_o are 0. The first access after reset is a write of 0x80 to address 0x00, where bit 7 is the transmitter power-down bit.
- R2: Once reg_req_o is raised, it stays high with reg_we_o, reg_addr_o and reg_wdata_o unchanged until reg_ack_i is sampled high on a clock edge. Each request completes exactly one access.
- R3: The status register at address 0x10 is read only after a rising edge on irq_i, passed through SYNC_STAGES flops. Without an interrupt no read is issued.
- R4: Lock is valid only when status bit 0 (locked) is 1 and bit 1 (lock lost) is 0. Bit 2 (subcarrier lock) and bits 7:3 have no effect. An invalid status returns the sequencer to waiting for an interrupt, with no write issued and capture_en_o left at 0.
- R5: After a valid lock, the power-down release write (0x00 to address 0x00) is issued only once rx_ready_i has been high. Until then no write is issued.
- R6: capture_en_o rises only after the release write has been acknowledged, and then stays high.
- R7: During capture, an interrupt triggers a status read. If lock is no longer valid, capture_en_o drops and 0x80 is written to address 0x00 again. If lock is still valid, capture_en_o stays high and no write is issued.
- R8: If no interrupt event arrives within wait_limit_i cycles of waiting, lock_err_o is set and the sequence restarts with a power-down write. lock_err_o clears when capture next starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Decoder interrupt line, asynchronous, active high |
| rx_ready_i | input | 1 | Receiver is ready to detect the clock lane start |
| wait_limit_i | input | TMR_W | Cycles to wait for an interrupt before retrying |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | 1 for a write, 0 for a read |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Write data |
| reg_ack_i | input | 1 | Access complete; read data valid in the same cycle |
| reg_rdata_i | input | DATA_W | Read data |
| capture_en_o | output | 1 | Receiver may capture video |
| lock_err_o | output | 1 | Interrupt wait timed out since capture last started |

## Verification
A wrong internal state shows up within a few tens of cycles. It appears either as a register access that should not exist, or as a missing one, on the request port. Examples are a status read with no interrupt, a second power-down write, or a release write while the receiver is not ready. It can also appear as capture_en_o taking the wrong level after an interrupt has been served. The bench drives distinct status bytes through one interrupt each. After each one it compares the access log and the capture level, and it also exercises the ready gate, loss of lock during capture, and the wait timeout.

// File: rtl/lockgate_pkg.sv
package lockgate_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_ASSERT_PWRDN,
        ST_WAIT_IRQ,
        ST_READ_STATUS,
        ST_CHECK_LOCK,
        ST_WAIT_RX_READY,
        ST_RELEASE_PWRDN,
        ST_CAPTURE,
        ST_CAPTURE_READ
    } seq_state_t;

    // Register addresses and bit positions the sequencer depends on
    localparam logic [7:0] PWR_REG_ADDR    = 8'h00;
    localparam logic [7:0] STATUS_REG_ADDR = 8'h10;
    localparam int         PWRDN_BIT       = 7;
    localparam int         LOCKED_BIT      = 0;
    localparam int         LOST_BIT        = 1;

endpackage

// File: rtl/lockgate_irq_sync.sv
module lockgate_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    output logic evt_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q[0] <= irq_i;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            last_q <= sync_q[STAGES-1];
        end
    end

    assign evt_o = sync_q[STAGES-1] & ~last_q;

    // R3: an interrupt produces a single-cycle event
    assert_single_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

endmodule

// File: rtl/lockgate_wait_timer.sv
module lockgate_wait_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [TMR_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q < limit_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q >= limit_i);

    // R8: a non-zero limit can only expire after waiting was already under way
    assert_expiry_needs_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && limit_i != '0) |-> $past(run_i));

endmodule

// File: rtl/lockgate_regport.sv
module lockgate_regport #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o       <= 1'b0;
            bus_we_o    <= 1'b0;
            bus_addr_o  <= '0;
            bus_wdata_o <= '0;
            done_o      <= 1'b0;
            rdata_o     <= '0;
        end else begin
            done_o <= 1'b0;
            if (req_o) begin
                if (ack_i) begin
                    req_o   <= 1'b0;
                    done_o  <= 1'b1;
                    rdata_o <= bus_rdata_i;
                end
            end else if (go_i) begin
                req_o       <= 1'b1;
                bus_we_o    <= we_i;
                bus_addr_o  <= addr_i;
                bus_wdata_o <= wdata_i;
            end
        end
    end

    // R2: request and its fields hold until acknowledged
    assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(bus_addr_o) && $stable(bus_we_o)
                               && $stable(bus_wdata_o)));

    // R2: completion only follows an acknowledged request
    assert_done_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(req_o && ack_i));

    // R2: a new access never starts over a pending one
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (!req_o && !done_o));

endmodule

// File: rtl/lockgate_seq.sv
module lockgate_seq
    import lockgate_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int TMR_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_i,
    input  logic              rx_ready_i,
    input  logic [TMR_W-1:0]  wait_limit_i,
    output logic              reg_req_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic              reg_ack_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              capture_en_o,
    output logic              lock_err_o
);
    localparam logic [ADDR_W-1:0] PWR_ADDR    = ADDR_W'(PWR_REG_ADDR);
    localparam logic [ADDR_W-1:0] STAT_ADDR   = ADDR_W'(STATUS_REG_ADDR);
    localparam logic [DATA_W-1:0] PWRDN_SET   = DATA_W'(1) << PWRDN_BIT;
    localparam logic [DATA_W-1:0] PWRDN_CLEAR = '0;

    seq_state_t        state_q, state_n;
    logic              irq_evt;
    logic              tmr_exp;
    logic              rp_done;
    logic [DATA_W-1:0] rp_rdata;
    logic              go_q, go_we_q;
    logic [ADDR_W-1:0] go_addr_q;
    logic [DATA_W-1:0] go_wdata_q;
    logic              lock_ok;
    logic              entering;

    lockgate_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_i (irq_i),
        .evt_o (irq_evt)
    );

    lockgate_wait_timer #(.TMR_W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_WAIT_IRQ),
        .limit_i   (wait_limit_i),
        .expired_o (tmr_exp)
    );

    lockgate_regport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go_q),
        .we_i        (go_we_q),
        .addr_i      (go_addr_q),
        .wdata_i     (go_wdata_q),
        .done_o      (rp_done),
        .rdata_o     (rp_rdata),
        .req_o       (reg_req_o),
        .bus_we_o    (reg_we_o),
        .bus_addr_o  (reg_addr_o),
        .bus_wdata_o (reg_wdata_o),
        .ack_i       (reg_ack_i),
        .bus_rdata_i (reg_rdata_i)
    );

    assign lock_ok  = rp_rdata[LOCKED_BIT] & ~rp_rdata[LOST_BIT];
    assign entering = (state_n != state_q);

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RESET:         state_n = ST_ASSERT_PWRDN;
            ST_ASSERT_PWRDN:  if (rp_done) state_n = ST_WAIT_IRQ;
            ST_WAIT_IRQ: begin
                if (irq_evt)      state_n = ST_READ_STATUS;
                else if (tmr_exp) state_n = ST_ASSERT_PWRDN;
            end
            ST_READ_STATUS:   if (rp_done) state_n = ST_CHECK_LOCK;
            ST_CHECK_LOCK:    state_n = lock_ok ? ST_WAIT_RX_READY : ST_WAIT_IRQ;
            ST_WAIT_RX_READY: if (rx_ready_i) state_n = ST_RELEASE_PWRDN;
            ST_RELEASE_PWRDN: if (rp_done) state_n = ST_CAPTURE;
            ST_CAPTURE:       if (irq_evt) state_n = ST_CAPTURE_READ;
            ST_CAPTURE_READ: begin
                if (rp_done) state_n = lock_ok ? ST_CAPTURE : ST_ASSERT_PWRDN;
            end
            default:          state_n = ST_RESET;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_n;
    end

    // Registered outputs and access launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capture_en_o <= 1'b0;
            lock_err_o   <= 1'b0;
            go_q         <= 1'b0;
            go_we_q      <= 1'b0;
            go_addr_q    <= '0;
            go_wdata_q   <= '0;
        end else begin
            capture_en_o <= (state_n == ST_CAPTURE) || (state_n == ST_CAPTURE_READ);
            go_q         <= 1'b0;
            if (entering) begin
                unique case (state_n)
                    ST_ASSERT_PWRDN: begin
                        go_q <= 1'b1; go_we_q <= 1'b1;
                        go_addr_q <= PWR_ADDR; go_wdata_q <= PWRDN_SET;
                    end
                    ST_RELEASE_PWRDN: begin
                        go_q <= 1'b1; go_we_q <= 1'b1;
                        go_addr_q <= PWR_ADDR; go_wdata_q <= PWRDN_CLEAR;
                    end
                    ST_READ_STATUS, ST_CAPTURE_READ: begin
                        go_q <= 1'b1; go_we_q <= 1'b0;
                        go_addr_q <= STAT_ADDR; go_wdata_q <= '0;
                    end
                    default: go_q <= 1'b0;
                endcase
            end
            if (state_q == ST_WAIT_IRQ && !irq_evt && tmr_exp)
                lock_err_o <= 1'b1;
            else if (state_q == ST_RELEASE_PWRDN && state_n == ST_CAPTURE)
                lock_err_o <= 1'b0;
        end
    end

    // R3: status is read only in response to an interrupt event
    assert_read_on_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_READ_STATUS) |-> $past(irq_evt));

    // R4: the ready wait is entered only from a valid lock status
    assert_valid_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RX_READY && $past(state_q) == ST_CHECK_LOCK)
            |-> $past(rp_rdata[LOCKED_BIT] && !rp_rdata[LOST_BIT]));

    // R5: power-down release starts only with the receiver ready
    assert_release_needs_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RELEASE_PWRDN) |-> $past(rx_ready_i));

    // R6: capture begins only after the release write completed
    assert_capture_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capture_en_o) |-> $past(state_q == ST_RELEASE_PWRDN && rp_done));

    // R7: a bad status during capture removes capture
    assert_lost_drops_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE_READ && rp_done && !lock_ok) |=> !capture_en_o);

endmodule

// File: tb/sim_lockgate_seq.sv
module sim_lockgate_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq;
    logic        rx_ready;
    logic [31:0] wait_limit;
    logic        reg_req, reg_we, reg_ack;
    logic [7:0]  reg_addr, reg_wdata, reg_rdata;
    logic        capture_en, lock_err;

    always #5 clk = ~clk;

    lockgate_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_i        (irq),
        .rx_ready_i   (rx_ready),
        .wait_limit_i (wait_limit),
        .reg_req_o    (reg_req),
        .reg_we_o     (reg_we),
        .reg_addr_o   (reg_addr),
        .reg_wdata_o  (reg_wdata),
        .reg_ack_i    (reg_ack),
        .reg_rdata_i  (reg_rdata),
        .capture_en_o (capture_en),
        .lock_err_o   (lock_err)
    );

    // {status byte, capture expected}
    localparam logic [8:0] VEC [0:7] = '{
        {8'h01, 1'b1}, {8'h00, 1'b0}, {8'h03, 1'b0}, {8'h02, 1'b0},
        {8'h05, 1'b1}, {8'h04, 1'b0}, {8'h07, 1'b0}, {8'hF9, 1'b1}
    };
    localparam int ACK_LAT = 2;

    int         checks = 0;
    int         errs   = 0;
    int         wr_cnt = 0;
    int         rd_cnt = 0;
    logic [7:0] wr_addr_log [0:63];
    logic [7:0] wr_data_log [0:63];
    logic [7:0] status_val = 8'h00;
    logic       finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_irq();
        @(negedge clk) irq = 1'b1;
        @(negedge clk) irq = 1'b0;
    endtask

    // Register bus responder
    initial begin
        int lat;
        lat = 0;
        reg_ack = 1'b0;
        reg_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (reg_ack) begin
                reg_ack = 1'b0;
            end else if (reg_req) begin
                if (lat == ACK_LAT) begin
                    reg_ack = 1'b1;
                    reg_rdata = status_val;
                    if (reg_we) begin
                        if (wr_cnt < 64) begin
                            wr_addr_log[wr_cnt] = reg_addr;
                            wr_data_log[wr_cnt] = reg_wdata;
                        end
                        wr_cnt++;
                    end else begin
                        rd_cnt++;
                    end
                    lat = 0;
                end else begin
                    lat++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        int w0, r0;
        rst_n = 1'b0; irq = 1'b0; rx_ready = 1'b0; wait_limit = 32'd1000;
        tick(3);
        chk("R1 capture in reset", 32'(capture_en), 0);
        chk("R1 error in reset",   32'(lock_err), 0);
        chk("R1 request in reset", 32'(reg_req), 0);
        @(negedge clk) rst_n = 1'b1;
        tick(20);
        chk("R1 one write after reset", wr_cnt, 1);
        chk("R1 powerdown address", 32'(wr_addr_log[0]), 32'h00);
        chk("R1 powerdown data",    32'(wr_data_log[0]), 32'h80);
        chk("R3 no read without interrupt", rd_cnt, 0);

        // R5: receiver not ready holds the release back
        status_val = 8'h01;
        pulse_irq();
        tick(40);
        chk("R5 no capture before ready", 32'(capture_en), 0);
        chk("R5 no release before ready", wr_cnt, 1);
        chk("R3 one read per interrupt", rd_cnt, 1);
        rx_ready = 1'b1;
        tick(20);
        chk("R6 capture after release", 32'(capture_en), 1);
        chk("R5 release write count", wr_cnt, 2);
        chk("R5 release data", 32'(wr_data_log[1]), 32'h00);

        // R7: interrupt with lock still valid
        pulse_irq();
        tick(30);
        chk("R7 capture kept", 32'(capture_en), 1);
        chk("R7 no write on valid", wr_cnt, 2);
        chk("R7 status read", rd_cnt, 2);

        // R7: lock lost during capture
        status_val = 8'h03;
        pulse_irq();
        tick(30);
        chk("R7 capture dropped", 32'(capture_en), 0);
        chk("R7 powerdown rewritten", wr_cnt, 3);
        chk("R7 powerdown data", 32'(wr_data_log[2]), 32'h80);

        // R4: table walk of status patterns
        for (int i = 0; i < 8; i++) begin
            w0 = wr_cnt;
            status_val = VEC[i][8:1];
            pulse_irq();
            tick(40);
            chk("R4 capture for status", 32'(capture_en), 32'(VEC[i][0]));
            if (VEC[i][0]) begin
                chk("R6 release logged", wr_cnt, w0 + 1);
                chk("R6 release data", 32'(wr_data_log[wr_cnt-1]), 32'h00);
                status_val = 8'h02;
                pulse_irq();
                tick(40);
                chk("R7 drop after lost", 32'(capture_en), 0);
                chk("R7 restart data", 32'(wr_data_log[wr_cnt-1]), 32'h80);
            end else begin
                chk("R4 no write on bad lock", wr_cnt, w0);
            end
        end

        // R8: interrupt wait timeout
        chk("R8 no error yet", 32'(lock_err), 0);
        w0 = wr_cnt;
        r0 = rd_cnt;
        wait_limit = 32'd50;
        tick(120);
        chk("R8 error raised", 32'(lock_err), 1);
        chk("R8 retry write", 32'(wr_cnt > w0), 1);
        chk("R8 retry data", 32'(wr_data_log[wr_cnt-1]), 32'h80);
        chk("R3 no read during timeouts", rd_cnt, r0);
        wait_limit = 32'd1000;
        tick(20);
        status_val = 8'h01;
        pulse_irq();
        tick(40);
        chk("R8 capture after retry", 32'(capture_en), 1);
        chk("R8 error cleared", 32'(lock_err), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule